// File: doc/BRIEF.md
# Serial Audio Capture to Byte FIFO Bridge

This block takes the three-wire serial output of a two-channel delta-sigma audio converter and turns it into a stream of bytes for an asynchronous USB byte FIFO. The three wires are a bit clock, a channel-select clock and a data line. Data bits are packed eight at a time. Each finished byte goes to the FIFO through a write strobe, and only when the FIFO reports free space.

The host restarts capture by sending any byte into the FIFO. The block reads that byte out with a read strobe, drops whatever it had partly assembled and clears its overflow flag. It then stays silent until the next rising edge of the channel clock, which marks the start of a left sample. Because of this, the host can cut the stream into 3-byte samples, left then right, without any framing bytes.

Every external line is brought into the system clock through a chain of synchronizer flops. Edges of the bit clock and the channel clock are detected in the system clock domain, so the system clock must run several times faster than the bit clock.

Top module: `adc_byte_bridge`

## Requirements
- R1: While reset is held and after it is released, the outputs sit at their idle values until capture begins: `wrStrobe` = 0, `rdStrobeN` = 1, `overflow` = 0, `fifoData` = 0.
- R2: Data is sampled on rising edges of the bit clock. Every 8 sampled bits form one byte, and the first bit received goes to bit 7 of the byte (MSB first). The FIFO receives exactly the byte that was shifted in.
- R3: Samples are 24-bit two's complement, and the channel clock is high for the left channel. Each stereo frame produces 6 bytes in this order: left high, middle and low byte, then right high, middle and low byte. No byte of a frame is skipped or repeated while space is available.
- R4: After reset or a host restart, serial data that arrives before the next rising edge of the channel clock is ignored. The first byte written is the high byte of the left sample of the frame that begins at that edge.
- R5: Each write strobe is high for exactly `STROBE_CYCLES` system clocks, and `fifoData` does not change while the strobe is high.
- R6: A byte is written only while the synchronized `txSpaceN` is low. A byte that completes while the FIFO is full is dropped, and `overflow` is set and stays set until the next host restart.
- R7: When `rxReadyN` goes low, the block issues one read strobe (`rdStrobeN` low for exactly `STROBE_CYCLES` clocks), clears `overflow`, throws away any partly assembled byte and waits again for a channel-clock rising edge (R4).
- R8: The write strobe and the read strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock from the converter |
| chanClk | input | 1 | Channel clock; high = left sample |
| serData | input | 1 | Serial sample data, changes on falling bit clock |
| txSpaceN | input | 1 | Low while the FIFO can accept a byte |
| rxReadyN | input | 1 | Low while a host byte waits in the FIFO |
| fifoData | output | BYTE_W | Byte presented to the FIFO |
| wrStrobe | output | 1 | Active-high write strobe |
| rdStrobeN | output | 1 | Active-low read strobe that discards the host byte |
| overflow | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |

## Verification
The bench first checks that data arriving mid-frame after reset, and after two host restarts issued in the left and right halves of a frame, never reaches the FIFO. A design that started capturing at once, or that waited for the wrong clock edge, would make its first byte something other than the left high byte of the next frame. Every written byte is compared with the byte the stimulus most recently finished, and consecutive writes must step through the six byte slots in order, so bit-order errors, byte-order errors and channel swaps all show up. A long full window checks that bytes are dropped rather than written, that the flag is sticky, and that a restart clears it. Both strobes are measured for width, and the write strobe is also checked for overlap with the read strobe.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  // Strobes from control to the datapath
  typedef struct packed {
    logic captureEn;   // shift sampled bits in
    logic clearShift;  // drop any partial byte
    logic loadOut;     // copy the finished byte to the FIFO data register
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_ALIGN,    // wait for channel clock rising edge
    ST_RUN,      // capture and write bytes
    ST_HOSTWAIT, // host byte seen, wait for write strobe to end
    ST_READ,     // read strobe active
    ST_RECOVER   // wait for host byte indication to clear
  } ctlState_t;

  localparam int SAMPLE_W = 24;

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitSync,
  input  logic              chanSync,
  input  logic              dataSync,
  input  dpCtl_t            ctl,
  output logic              chanRise,
  output logic              byteDone,
  output logic [BYTE_W-1:0] fifoData
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              bitPrev, chanPrev;
  logic              bitRise;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] byteReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] nextShift;

  assign bitRise   = bitSync & ~bitPrev;
  assign chanRise  = chanSync & ~chanPrev;
  assign nextShift = {shiftReg[BYTE_W-2:0], dataSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPrev  <= 1'b0;
      chanPrev <= 1'b0;
      shiftReg <= '0;
      byteReg  <= '0;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      fifoData <= '0;
    end else begin
      bitPrev  <= bitSync;
      chanPrev <= chanSync;
      byteDone <= 1'b0;
      if (ctl.clearShift) begin
        shiftReg <= '0;
        bitCnt   <= '0;
      end else if (ctl.captureEn && bitRise) begin
        shiftReg <= nextShift;
        if (bitCnt == LAST_BIT) begin
          bitCnt   <= '0;
          byteReg  <= nextShift;
          byteDone <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (ctl.loadOut) fifoData <= byteReg;
    end
  end

endmodule

// File: rtl/bridge_control.sv
module bridge_control
  import bridge_pkg::*;
#(
  parameter int STROBE_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   chanRise,
  input  logic   byteDone,
  input  logic   spaceOk,
  input  logic   hostAvail,
  output dpCtl_t ctl,
  output logic   wrStrobe,
  output logic   rdStrobeN,
  output logic   overflow
);

  localparam int SC_W = $clog2(STROBE_CYCLES + 1);
  localparam logic [SC_W-1:0] STROBE_LAST = SC_W'(STROBE_CYCLES - 1);

  ctlState_t       state;
  logic [SC_W-1:0] wrCnt, rdCnt;
  logic            writeSlot, canWrite;

  assign writeSlot = (state == ST_RUN) && byteDone && !hostAvail;
  assign canWrite  = spaceOk && !wrStrobe;

  always_comb begin
    ctl.captureEn  = (state == ST_RUN);
    ctl.clearShift = (state != ST_RUN);
    ctl.loadOut    = writeSlot && canWrite;
  end

  // Sequencing and read strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ALIGN;
      rdStrobeN <= 1'b1;
      rdCnt     <= '0;
      overflow  <= 1'b0;
    end else begin
      case (state)
        ST_ALIGN: begin
          if (hostAvail) begin
            state    <= ST_HOSTWAIT;
            overflow <= 1'b0;
          end else if (chanRise) begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (hostAvail) begin
            state    <= ST_HOSTWAIT;
            overflow <= 1'b0;
          end else if (writeSlot && !canWrite) begin
            overflow <= 1'b1;
          end
        end
        ST_HOSTWAIT: begin
          if (!wrStrobe) begin
            rdStrobeN <= 1'b0;
            rdCnt     <= STROBE_LAST;
            state     <= ST_READ;
          end
        end
        ST_READ: begin
          if (rdCnt == '0) begin
            rdStrobeN <= 1'b1;
            state     <= ST_RECOVER;
          end else begin
            rdCnt <= rdCnt - 1'b1;
          end
        end
        ST_RECOVER: begin
          if (!hostAvail) state <= ST_ALIGN;
        end
        default: state <= ST_ALIGN;
      endcase
    end
  end

  // Write strobe with fixed minimum width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrCnt    <= '0;
    end else if (ctl.loadOut) begin
      wrStrobe <= 1'b1;
      wrCnt    <= STROBE_LAST;
    end else if (wrStrobe) begin
      if (wrCnt == '0) wrStrobe <= 1'b0;
      else             wrCnt    <= wrCnt - 1'b1;
    end
  end

endmodule

// File: rtl/adc_byte_bridge.sv
module adc_byte_bridge
  import bridge_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int STROBE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              chanClk,
  input  logic              serData,
  input  logic              txSpaceN,
  input  logic              rxReadyN,
  output logic [BYTE_W-1:0] fifoData,
  output logic              wrStrobe,
  output logic              rdStrobeN,
  output logic              overflow
);

  localparam int SYNC_W = 5;
  localparam logic [SYNC_W-1:0] SYNC_RESET = 5'b00011;

  logic [SYNC_W-1:0] syncBus;
  logic   bitSync, chanSync, dataSync, spaceOk, hostAvail;
  logic   chanRise, byteDone;
  dpCtl_t ctl;

  bridge_sync #(
    .WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RESET)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({bitClk, chanClk, serData, txSpaceN, rxReadyN}),
    .syncOut(syncBus)
  );

  assign bitSync   = syncBus[4];
  assign chanSync  = syncBus[3];
  assign dataSync  = syncBus[2];
  assign spaceOk   = ~syncBus[1];
  assign hostAvail = ~syncBus[0];

  bridge_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .bitSync(bitSync), .chanSync(chanSync), .dataSync(dataSync),
    .ctl(ctl), .chanRise(chanRise), .byteDone(byteDone), .fifoData(fifoData)
  );

  bridge_control #(.STROBE_CYCLES(STROBE_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN),
    .chanRise(chanRise), .byteDone(byteDone),
    .spaceOk(spaceOk), .hostAvail(hostAvail),
    .ctl(ctl), .wrStrobe(wrStrobe), .rdStrobeN(rdStrobeN), .overflow(overflow)
  );

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int BYTE_W        = 8,
  parameter int STROBE_CYCLES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic              rdStrobeN,
  input logic              overflow,
  input logic [BYTE_W-1:0] fifoData,
  input logic              spaceOk,
  input logic              hostAvail
);

  logic [15:0] wrLen, rdLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLen <= '0;
      rdLen <= '0;
    end else begin
      wrLen <= wrStrobe ? wrLen + 1'b1 : '0;
      rdLen <= !rdStrobeN ? rdLen + 1'b1 : '0;
    end
  end

  assert_wr_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrStrobe) |-> wrLen == 16'(STROBE_CYCLES));

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && $past(wrStrobe)) |-> $stable(fifoData));

  assert_write_needs_space_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStrobe) |-> $past(spaceOk));

  assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(!spaceOk || wrStrobe));

  assert_rd_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobeN) |-> rdLen == 16'(STROBE_CYCLES));

  assert_rd_clears_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobeN |-> !overflow);

  assert_rd_on_host_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdStrobeN) |-> $past(hostAvail));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && !rdStrobeN));

endmodule

bind adc_byte_bridge bridge_checker #(
  .BYTE_W(BYTE_W), .STROBE_CYCLES(STROBE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .rdStrobeN(rdStrobeN),
  .overflow(overflow), .fifoData(fifoData), .spaceOk(spaceOk), .hostAvail(hostAvail)
);

// File: tb/sim_adc_byte_bridge.sv
module sim_adc_byte_bridge;
  localparam int STROBE   = 4;
  localparam int BIT_HALF = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, bitClk, chanClk, serData, txSpaceN, rxReadyN;
  logic [7:0] fifoData;
  logic wrStrobe, rdStrobeN, overflow;

  adc_byte_bridge #(.BYTE_W(8), .SYNC_STAGES(2), .STROBE_CYCLES(STROBE)) u0 (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .chanClk(chanClk), .serData(serData),
    .txSpaceN(txSpaceN), .rxReadyN(rxReadyN), .fifoData(fifoData),
    .wrStrobe(wrStrobe), .rdStrobeN(rdStrobeN), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  int genFrame = 0, genBit = 30;
  int lastFrame = -1, lastSlot = -1;
  logic [7:0] lastByte = 8'h00;
  bit genRun = 0, monEn = 0, expectFirst = 0, gapOk = 0, finished = 0;
  int firstFrame = 0, prevSlot = -1, writes = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // left = {frame, 3C, ~frame}; right = {C3, frame, frame+11}
  function automatic logic [23:0] sampleOf(input int f, input bit right);
    logic [7:0] id = 8'(f);
    return right ? {8'hC3, id, id + 8'h11} : {id, 8'h3C, ~id};
  endfunction

  function automatic logic [7:0] byteOf(input int f, input int slot);
    logic [23:0] s = sampleOf(f, slot >= 3);
    return s[8*(2 - slot % 3) +: 8];
  endfunction

  // Converter model: data and channel clock change at falling bit clock
  initial begin
    logic [23:0] s;
    bitClk = 0; chanClk = 0; serData = 0;
    wait (genRun);
    forever begin
      @(negedge clk);
      bitClk  = 0;
      chanClk = (genBit < 24);
      s       = sampleOf(genFrame, genBit >= 24);
      serData = s[23 - (genBit % 24)];
      repeat (BIT_HALF - 1) @(negedge clk);
      @(negedge clk);
      bitClk = 1;
      if (genBit % 8 == 7) begin
        lastSlot  = genBit / 8;
        lastFrame = genFrame;
        lastByte  = byteOf(genFrame, lastSlot);
      end
      repeat (BIT_HALF - 1) @(negedge clk);
      genBit++;
      if (genBit == 48) begin
        genBit = 0;
        genFrame++;
      end
    end
  end

  // FIFO-side monitor
  bit prevW = 0, prevR = 1;
  int wrLen = 0, rdLen = 0;
  logic [7:0] heldData;
  always @(negedge clk) begin
    if (monEn) begin
      if (wrStrobe && !prevW) begin
        writes++;
        check(fifoData == lastByte, "R2 byte value", fifoData, lastByte);
        check(rdStrobeN == 1'b1, "R8 read strobe during write", rdStrobeN, 1);
        if (expectFirst) begin
          check(lastSlot == 0 && lastFrame == firstFrame, "R4 first byte after align",
                lastFrame * 8 + lastSlot, firstFrame * 8);
          expectFirst = 0;
        end else if (gapOk) begin
          gapOk = 0;
        end else begin
          check(lastSlot == (prevSlot + 1) % 6, "R3 byte order", lastSlot, (prevSlot + 1) % 6);
        end
        prevSlot = lastSlot;
        heldData = fifoData;
      end
      if (wrStrobe && prevW && fifoData !== heldData)
        check(0, "R5 data changed during strobe", fifoData, heldData);
      if (!wrStrobe && prevW)
        check(wrLen == STROBE, "R5 write strobe width", wrLen, STROBE);
      if (rdStrobeN && !prevR)
        check(rdLen == STROBE, "R7 read strobe width", rdLen, STROBE);
      wrLen = wrStrobe ? wrLen + 1 : 0;
      rdLen = !rdStrobeN ? rdLen + 1 : 0;
    end
    prevW = wrStrobe;
    prevR = rdStrobeN;
  end

  task automatic hostRestart(input int atBit);
    int f;
    while (genBit != atBit) @(negedge clk);
    f = genFrame;
    firstFrame  = f + 1;
    expectFirst = 1;
    rxReadyN = 0;
    wait (!rdStrobeN);
    @(negedge clk);
    check(overflow == 1'b0, "R7 overflow cleared by restart", overflow, 0);
    wait (rdStrobeN);
    @(negedge clk);
    rxReadyN = 1;
  endtask

  initial begin
    int w0;
    rstN = 0; txSpaceN = 0; rxReadyN = 1;
    repeat (5) @(negedge clk);
    check(wrStrobe == 0, "R1 reset write strobe", wrStrobe, 0);
    check(rdStrobeN == 1, "R1 reset read strobe", rdStrobeN, 1);
    check(overflow == 0, "R1 reset overflow", overflow, 0);
    check(fifoData == 0, "R1 reset data", fifoData, 0);
    rstN = 1;
    monEn = 1;
    expectFirst = 1;
    firstFrame = 1;
    genRun = 1;
    repeat (200) @(negedge clk);
    check(writes == 0, "R1 R4 no write before frame edge", writes, 0);

    // Free-running capture over several frames
    wait (writes >= 30);

    // FIFO full window
    wait (wrStrobe);
    wait (!wrStrobe);
    @(negedge clk);
    txSpaceN = 1;
    w0 = writes;
    repeat (400) @(negedge clk);
    check(writes == w0, "R6 no write while full", writes, w0);
    check(overflow == 1, "R6 overflow set", overflow, 1);
    gapOk = 1;
    txSpaceN = 0;
    wait (writes >= w0 + 7);
    check(overflow == 1, "R6 overflow sticky", overflow, 1);

    // Restart in the left half, then in the right half
    hostRestart(10);
    w0 = writes;
    wait (writes >= w0 + 12);
    check(expectFirst == 0, "R7 capture resumed", expectFirst, 0);
    hostRestart(40);
    w0 = writes;
    wait (writes >= w0 + 12);
    check(expectFirst == 0, "R7 capture resumed after second restart", expectFirst, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule